// File: doc/BRIEF.md
# Serial ADC Result Reader

This block is the host-side master for a 12-bit successive-approximation converter that talks over three wires: an active-low chip select, a data clock and a serial data line. It runs on the system clock. A pulse on `start` begins a read. The block lowers chip select and produces the data clock from a divider whose half-period is programmable in system cycles. It then passes over the converter's sample window and its low null bit, and shifts the result in most significant bit first. Each bit is sampled on a rising data-clock edge, because the converter changes its data line on the falling edge.

A read can be cut short after 3 to 12 result bits. The bits that were not read come back as zero. A full 12-bit read can also keep clocking to collect the 11 bits that the converter repeats in reverse order. The block compares each repeated bit with the word already captured and raises a flag on any difference. When a read ends, chip select goes high, the clock is brought back low and the clock stays idle for a guard interval. The result then sits on the outputs until the next read.

The controller is a four-state machine. ST_IDLE goes to ST_ACTIVE on an accepted start. ST_ACTIVE goes to ST_FINISH on the final capture edge. ST_FINISH goes to ST_GAP on the next divider tick, which lowers the clock. ST_GAP returns to ST_IDLE after two more divider ticks.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `valid`=0, `result`=0, `bits_read`=0 and `replay_mismatch`=0.
- R2: A `start` pulse seen while `busy`=0 pulls `cs_n` low and raises `busy` on the next cycle. A `start` seen while `busy`=1 is ignored and is not queued.
- R3: While `busy`=1, each high phase and each low phase of `sclk` lasts exactly H system cycles. H is the larger of `half_div` and MIN_HALF, where MIN_HALF = ceil(400 ns × SYS_CLK_HZ). The first rising edge comes H cycles after `cs_n` falls.
- R4: Rising edges 1 and 2 (sample window) and rising edge 3 (null bit) are not stored. Rising edge 4+k stores the data line into `result` bit 11−k, so the most significant bit comes first, in straight binary.
- R5: At start, N = `bit_count` is latched after clamping to the range 3..12. After rising edge 3+N, the read ends. The bits of `result` below bit 12−N read 0, and `bits_read` reports N.
- R6: If `replay_en`=1 is latched and N=12, clocking goes on through rising edge 26. The bit taken at edge 15+r (r=1..11) is compared with `result` bit r, and `replay_mismatch` is 1 exactly when some pair differs. Otherwise no extra edges are made and `replay_mismatch` is 0.
- R7: `valid` is a one-cycle pulse. It comes in the first cycle that `cs_n` is high after a read. `result`, `bits_read` and `replay_mismatch` are updated there and held until the next pulse.
- R8: After `cs_n` rises, `sclk` falls H cycles later. `cs_n` then stays high with `sclk` low for 2H more cycles before `busy` drops, so `cs_n` is high for 3H cycles while `busy`=1. `sclk` never rises while `cs_n` stays high.
- R9: Changes on `half_div`, `bit_count` and `replay_en` while `busy`=1 have no effect on the read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read (accepted only when idle) |
| half_div | input | DIV_W | Requested data-clock half-period in system cycles |
| bit_count | input | CNT_W | Number of result bits to read (clamped to 3..12) |
| replay_en | input | 1 | Collect and compare the reversed repeat on full reads |
| sdo | input | 1 | Serial data from the converter |
| sclk | output | 1 | Data clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A read or its guard interval is in progress |
| valid | output | 1 | One-cycle pulse: result fields updated |
| result | output | RES_BITS | Captured word, MSB-aligned |
| bits_read | output | CNT_W | Number of result bits captured in the last read |
| replay_mismatch | output | 1 | Reversed repeat differed from the captured word |

## Verification
The bench instantiates the reader with SYS_CLK_HZ set to 10 MHz, which makes MIN_HALF equal to 4 system cycles. At that size every requested bit count from 0 to 15, with replay on and off, can be swept against several divider settings in one run. Those settings fall below, at and above the minimum, so every clamping case and every short-cycle length is covered. A behavioural converter model drives the data line on falling clock edges and can flip any single replayed bit. A mid-read disturbance of every latched input checks that those inputs are held for the whole read.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FINISH = 2'd2,
        ST_GAP    = 2'd3
    } rd_state_t;

    // Rising edges spent in the converter's sample window before the null bit.
    localparam int SAMPLE_RISES = 2;

endpackage

// File: rtl/adc_sclk_divider.sv
module adc_sclk_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;

    // A tick marks the last system cycle of a data-clock half-period.
    assign tick = run && (cnt_q == (half - ONE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
    parameter int RES_BITS     = 12,
    parameter int SAMPLE_RISES = 2,
    parameter int CNT_W        = 4,
    parameter int EDGE_W       = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                rise,
    input  logic                sdo,
    input  logic [CNT_W-1:0]    n_bits,
    input  logic                replay_on,
    output logic [RES_BITS-1:0] word_nxt,
    output logic                mism_nxt,
    output logic [CNT_W-1:0]    got_nxt,
    output logic                last_edge
);
    localparam int FIRST_DATA   = SAMPLE_RISES + 2;
    localparam int FIRST_REPLAY = FIRST_DATA + RES_BITS;
    localparam int LAST_REPLAY  = FIRST_REPLAY + RES_BITS - 2;
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [EDGE_W-1:0] EDGE_ONE = EDGE_W'(1);

    logic [EDGE_W-1:0]   edge_q;
    logic [RES_BITS-1:0] word_q;
    logic                mism_q;
    logic [CNT_W-1:0]    got_q;

    int   evt;
    int   data_pos;
    int   rep_pos;
    logic data_hit;
    logic rep_hit;
    logic rep_bit;

    always_comb begin
        evt      = int'(edge_q) + 1;
        data_pos = evt - FIRST_DATA;
        rep_pos  = evt - FIRST_REPLAY + 1;
        data_hit = rise && (data_pos >= 0) && (data_pos < int'(n_bits));
        rep_hit  = rise && replay_on && (evt >= FIRST_REPLAY) && (evt <= LAST_REPLAY);
        word_nxt = word_q;
        rep_bit  = 1'b0;
        for (int b = 0; b < RES_BITS; b++) begin
            if (data_hit && ((RES_BITS - 1 - b) == data_pos)) begin
                word_nxt[b] = sdo;
            end
            if (b == rep_pos) begin
                rep_bit = word_q[b];
            end
        end
        mism_nxt = mism_q | (rep_hit & (sdo ^ rep_bit));
        got_nxt  = data_hit ? (got_q + CNT_ONE) : got_q;
        if (replay_on) begin
            last_edge = rise && (evt == LAST_REPLAY);
        end else begin
            last_edge = rise && (evt == (FIRST_DATA - 1 + int'(n_bits)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            edge_q <= '0;
            word_q <= '0;
            mism_q <= 1'b0;
            got_q  <= '0;
        end else if (rise) begin
            edge_q <= edge_q + EDGE_ONE;
            word_q <= word_nxt;
            mism_q <= mism_nxt;
            got_q  <= got_nxt;
        end
    end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_reader_pkg::*;
#(
    parameter int SYS_CLK_HZ   = 250_000_000,
    parameter int MIN_PHASE_NS = 400,
    parameter int RES_BITS     = 12,
    parameter int MIN_SHORT    = 3,
    parameter int DIV_W        = 16,
    parameter int CNT_W        = $clog2(RES_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [CNT_W-1:0]    bit_count,
    input  logic                replay_en,
    input  logic                sdo,
    output logic                sclk,
    output logic                cs_n,
    output logic                busy,
    output logic                valid,
    output logic [RES_BITS-1:0] result,
    output logic [CNT_W-1:0]    bits_read,
    output logic                replay_mismatch
);
    localparam int EDGE_W       = $clog2(2 * RES_BITS + SAMPLE_RISES + 2);
    localparam int MIN_HALF_RAW = (MIN_PHASE_NS * (SYS_CLK_HZ / 1000) + 999_999) / 1_000_000;
    localparam int MIN_HALF     = (MIN_HALF_RAW < 1) ? 1 : MIN_HALF_RAW;
    localparam logic [DIV_W-1:0] MIN_HALF_V = DIV_W'(MIN_HALF);
    localparam logic [CNT_W-1:0] MIN_N      = CNT_W'(MIN_SHORT);
    localparam logic [CNT_W-1:0] MAX_N      = CNT_W'(RES_BITS);

    rd_state_t state_q, state_d;

    logic [DIV_W-1:0] half_q;
    logic [CNT_W-1:0] nbits_q;
    logic             replay_q;
    logic             gap_q;

    logic [DIV_W-1:0] eff_half;
    logic [CNT_W-1:0] n_clamp;
    logic             start_ok;
    logic             tick;
    logic             rise;

    logic [RES_BITS-1:0] word_nxt;
    logic                mism_nxt;
    logic [CNT_W-1:0]    got_nxt;
    logic                last_edge;

    // Settings are clamped here and latched only on an accepted start.
    always_comb begin
        eff_half = (half_div < MIN_HALF_V) ? MIN_HALF_V : half_div;
        if (bit_count < MIN_N) begin
            n_clamp = MIN_N;
        end else if (bit_count > MAX_N) begin
            n_clamp = MAX_N;
        end else begin
            n_clamp = bit_count;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign start_ok = start && (state_q == ST_IDLE);
    assign rise     = (state_q == ST_ACTIVE) && tick && !sclk;

    adc_sclk_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (half_q),
        .tick  (tick)
    );

    adc_bit_capture #(
        .RES_BITS     (RES_BITS),
        .SAMPLE_RISES (SAMPLE_RISES),
        .CNT_W        (CNT_W),
        .EDGE_W       (EDGE_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .rise      (rise),
        .sdo       (sdo),
        .n_bits    (nbits_q),
        .replay_on (replay_q),
        .word_nxt  (word_nxt),
        .mism_nxt  (mism_nxt),
        .got_nxt   (got_nxt),
        .last_edge (last_edge)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok)         state_d = ST_ACTIVE;
            ST_ACTIVE: if (last_edge)        state_d = ST_FINISH;
            ST_FINISH: if (tick)             state_d = ST_GAP;
            ST_GAP:    if (tick && gap_q)    state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Outputs and per-read registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk            <= 1'b0;
            cs_n            <= 1'b1;
            valid           <= 1'b0;
            result          <= '0;
            bits_read       <= '0;
            replay_mismatch <= 1'b0;
            half_q          <= MIN_HALF_V;
            nbits_q         <= MIN_N;
            replay_q        <= 1'b0;
            gap_q           <= 1'b0;
        end else begin
            valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sclk  <= 1'b0;
                    gap_q <= 1'b0;
                    if (start_ok) begin
                        cs_n     <= 1'b0;
                        half_q   <= eff_half;
                        nbits_q  <= n_clamp;
                        replay_q <= replay_en && (n_clamp == MAX_N);
                    end
                end
                ST_ACTIVE: begin
                    if (tick) begin
                        sclk <= !sclk;
                    end
                    if (last_edge) begin
                        cs_n            <= 1'b1;
                        valid           <= 1'b1;
                        result          <= word_nxt;
                        bits_read       <= got_nxt;
                        replay_mismatch <= mism_nxt;
                    end
                end
                ST_FINISH: begin
                    gap_q <= 1'b0;
                    if (tick) begin
                        sclk <= 1'b0;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gap_q <= 1'b1;
                    end
                end
                default: begin
                    sclk <= 1'b0;
                    cs_n <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
    parameter int RES_BITS  = 12,
    parameter int MIN_SHORT = 3,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sclk,
    input logic             cs_n,
    input logic             busy,
    input logic             valid,
    input logic [CNT_W-1:0] bits_read,
    input logic             replay_mismatch
);

    a_r2_start_lowers_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !cs_n);

    a_r2_cs_low_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r7_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cs_n && busy && !$past(cs_n)));

    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((int'(bits_read) >= MIN_SHORT) && (int'(bits_read) <= RES_BITS)));

    a_r6_short_no_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (int'(bits_read) != RES_BITS)) |-> !replay_mismatch);

    a_r8_no_rise_while_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !(sclk && !$past(sclk)));

endmodule

bind adc_serial_reader adc_serial_reader_chk #(
    .RES_BITS  (RES_BITS),
    .MIN_SHORT (MIN_SHORT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .sclk            (sclk),
    .cs_n            (cs_n),
    .busy            (busy),
    .valid           (valid),
    .bits_read       (bits_read),
    .replay_mismatch (replay_mismatch)
);

// File: tb/tb_adc_serial_reader.sv
module tb_adc_serial_reader;
    localparam int RES   = 12;
    localparam int DIV_W = 16;
    localparam int CNT_W = 4;
    localparam int MIN_H = 4;   // 400 ns at a 10 MHz system clock

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [DIV_W-1:0] half_div;
    logic [CNT_W-1:0] bit_count;
    logic             replay_en;
    logic             sdo;
    logic             sclk, cs_n, busy, valid, replay_mismatch;
    logic [RES-1:0]   result;
    logic [CNT_W-1:0] bits_read;

    always #2 clk = ~clk;

    adc_serial_reader #(.SYS_CLK_HZ(10_000_000)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .bit_count(bit_count), .replay_en(replay_en), .sdo(sdo),
        .sclk(sclk), .cs_n(cs_n), .busy(busy), .valid(valid),
        .result(result), .bits_read(bits_read), .replay_mismatch(replay_mismatch)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter model: data changes on falling data-clock edges.
    logic [RES-1:0] m_word = '0;
    int             m_corrupt = 0;
    int             fc = 0;

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) fc = 0;
        else      fc = fc + 1;
    end

    always_comb begin
        if (fc == 2)                    sdo = 1'b0;
        else if (fc >= 3 && fc <= 14)   sdo = m_word[14 - fc];
        else if (fc >= 15 && fc <= 25)  sdo = m_word[fc - 14] ^ (m_corrupt == fc - 14);
        else                            sdo = 1'b1;
    end

    // Frame monitor sampled away from the active edge.
    int   mon_h = MIN_H;
    int   mon_rises = 0, mon_bad = 0, mon_cshigh = 0, mon_run = 0;
    logic prev_sclk = 1'b0, prev_busy = 1'b0;

    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            mon_rises = 0; mon_bad = 0; mon_cshigh = 0; mon_run = 1;
        end else if (busy) begin
            if (sclk == prev_sclk) mon_run++;
            else begin
                if (mon_run != mon_h) mon_bad++;
                if (sclk) mon_rises++;
                mon_run = 1;
            end
        end
        if (busy && cs_n) mon_cshigh++;
        prev_sclk = sclk;
        prev_busy = busy;
    end

    task automatic do_read(input logic [RES-1:0] w, input int hd, input int nb,
                           input bit rep, input int corrupt, input bit disturb);
        int h, ne, rises_exp, t;
        logic [RES-1:0] exp_w;
        bit full;
        h         = (hd < MIN_H) ? MIN_H : hd;
        ne        = (nb < 3) ? 3 : ((nb > RES) ? RES : nb);
        exp_w     = w & (12'hFFF << (RES - ne));
        full      = rep && (ne == RES);
        rises_exp = full ? 26 : 3 + ne;
        m_word = w; m_corrupt = corrupt; mon_h = h;
        @(negedge clk);
        start = 1'b1; half_div = hd[DIV_W-1:0]; bit_count = nb[CNT_W-1:0]; replay_en = rep;
        @(negedge clk);
        start = 1'b0;
        check_eq("R2 cs_n low after start", int'(cs_n), 0);
        check_eq("R2 busy after start", int'(busy), 1);
        if (disturb) begin
            repeat (3 * h) @(negedge clk);
            start = 1'b1; bit_count = 4'd5; replay_en = !rep; half_div = 16'd9;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!valid && t < 5000) begin @(negedge clk); t++; end
        check_eq("R7 valid pulse seen", int'(valid), 1);
        check_eq("R4/R5 result word", int'(result), int'(exp_w));
        check_eq("R5 bits_read", int'(bits_read), ne);
        check_eq("R6 replay_mismatch", int'(replay_mismatch), int'(full && corrupt != 0));
        check_eq("R7 cs_n high at valid", int'(cs_n), 1);
        @(negedge clk);
        check_eq("R7 valid single cycle", int'(valid), 0);
        check_eq("R7 result held", int'(result), int'(exp_w));
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        check_eq("R6/R5 rising edge count", mon_rises, rises_exp);
        check_eq("R3 half-period violations", mon_bad, 0);
        check_eq("R8 release interval", mon_cshigh, 3 * h);
        if (disturb) begin
            repeat (3) @(negedge clk);
            check_eq("R9/R2 no queued start", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int hds[5] = '{0, 3, 4, 6, 9};
        rst_n = 1'b0; start = 1'b0; half_div = '0; bit_count = '0; replay_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 cs_n", int'(cs_n), 1);
        check_eq("R1 sclk", int'(sclk), 0);
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 valid", int'(valid), 0);
        check_eq("R1 result", int'(result), 0);
        check_eq("R1 bits_read", int'(bits_read), 0);
        check_eq("R1 replay_mismatch", int'(replay_mismatch), 0);

        // Sweep: divider settings x bit counts x replay.
        for (int hi = 0; hi < 4; hi++)
            for (int nb = 0; nb < 16; nb++)
                for (int rp = 0; rp < 2; rp++)
                    do_read(12'((nb * 397 + rp * 1234 + hi * 77 + 'h5A5) & 'hFFF),
                            hds[hi], nb, rp[0], 0, 1'b0);

        // Boundary words, full reads with replay.
        do_read(12'h000, 4, 12, 1'b1, 0, 1'b0);
        do_read(12'hFFF, 4, 12, 1'b1, 0, 1'b0);
        do_read(12'h800, 9, 12, 1'b1, 0, 1'b0);
        do_read(12'h7FF, 5, 12, 1'b1, 0, 1'b0);

        // R6: single corrupted replay bit at each position.
        for (int c = 1; c <= 11; c++) do_read(12'hA5C, 4, 12, 1'b1, c, 1'b0);
        // R6: corruption not examined on a short read.
        do_read(12'hA5C, 4, 11, 1'b1, 3, 1'b0);

        // R9: inputs disturbed mid-read.
        do_read(12'h3C9, 6, 12, 1'b0, 0, 1'b1);
        do_read(12'hC36, 4, 7, 1'b1, 0, 1'b1);
        do_read(12'h1E7, 5, 12, 1'b1, 2, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule